// File: doc/BRIEF.md
# Two-Phase Page DMA Engine

This block moves one fixed-size page (512 bytes by default) between an on-chip page buffer and system memory. Every transfer takes two phases. The internal phase exchanges bytes between the buffer and the flash data lines. The memory phase exchanges 32-bit words between the buffer and system memory through a simple request/acknowledge master port.

A page read runs the internal phase first, which fills the buffer from the flash. It then runs the memory phase, which copies the buffer out to memory. A page write runs the memory phase first and then the internal phase, which drains the buffer to the flash.

Software starts each phase on its own through the settings register. Each completed phase sets its own status bit, and each status bit can raise the interrupt. A one-cycle done pulse marks the end of the second phase.

Top module: `pgdma_engine`

## Requirements
- R1: After reset, all four registers read zero, and `irq`, `done`, `mem_req`, `fl_in_ready` and `fl_out_valid` are low.
- R2: A memory phase issues exactly 128 word beats. Beat i uses the address `base + 4*i`. `base` is the address register, with bits 1:0 forced to zero, captured when the phase starts.
- R3: Page read, internal phase: the engine accepts 512 bytes on `fl_in_*`, and accepted byte k becomes page offset k. Page read, memory phase: the engine writes with `mem_we`=1, and word i carries offsets 4i..4i+3 little-endian (offset 4i in bits 7:0).
- R4: Page write, memory phase: the engine reads 128 words with `mem_we`=0 into the buffer, using the same little-endian layout. Page write, internal phase: the engine presents the 512 bytes on `fl_out_*` in offset order.
- R5: A settings write that sets a select bit is accepted only when all of these hold. The engine is idle. Exactly one select bit is set. The selected phase is the one the sequence expects: the internal phase first when the direction bit is 1, the memory phase first when it is 0, and the other phase second. Any other select write leaves the settings unchanged, starts nothing and sets the error status bit.
- R6: The settings register (register 0) holds bit0 = direction (1 = page read), bit1 = internal-phase select and bit2 = memory-phase select. The two select bits are never both set. When a phase completes, the engine clears that phase's select bit and does not start the next phase by itself.
- R7: The status register (register 3) holds bit0 = internal phase complete, bit1 = memory phase complete and bit2 = error. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R8: `irq` is the OR of status AND interrupt enable (register 2, same bit positions), registered one cycle behind. With enable zero, `irq` is low.
- R9: `done` pulses for one cycle when the second phase of a transfer completes. It does not pulse after the first phase.
- R10: `mem_err` during the memory phase ends the phase. It sets the error bit but not the memory-complete bit, clears the memory select bit, drops `mem_req`, gives no `done`, and returns the sequence to the first phase.
- R11: A settings write with neither select bit set stops any active phase without setting status, and returns the sequence to the first phase.
- R12: `mem_req` holds with a stable address and direction until `mem_ack` or `mem_err`. `fl_out_valid` holds with stable data until `fl_out_ready`.
- R13: Register 1 is the 32-bit address register and reads back as written. `reg_rdata` shows the register selected by `reg_addr` one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 settings, 1 address, 2 irq enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat direction, 1 = write to memory |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Beat write data |
| mem_ack | input | 1 | Beat accepted |
| mem_err | input | 1 | Beat failed |
| mem_rdata | input | 32 | Beat read data |
| fl_in_valid | input | 1 | Flash byte available |
| fl_in_data | input | 8 | Flash byte in |
| fl_in_ready | output | 1 | Engine accepts a flash byte |
| fl_out_valid | output | 1 | Byte for flash available |
| fl_out_data | output | 8 | Byte to flash |
| fl_out_ready | input | 1 | Flash takes the byte |

## Verification
The bench aims at sequencing errors:
- Starting a phase out of order, or while busy, or with both selects set, must raise the error bit and start nothing. An engine that accepts such a write would emit memory beats that the scoreboard does not expect.
- A memory error injected mid-page must leave the memory-complete bit clear and rewind the sequence. A design that kept the sequence position would accept a memory-phase restart.
- An abort in the middle of a fill, followed by a full refill, must show data from offset zero. A counter that is not reset would shift every memory word.
- Stalls on both the flash and memory sides catch data that changes before its handshake.

// File: rtl/pgdma_pkg.sv
package pgdma_pkg;
  typedef enum logic [1:0] {
    RA_SET  = 2'd0,
    RA_ADDR = 2'd1,
    RA_IEN  = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;

  localparam int SB_DIR = 0;
  localparam int SB_INT = 1;
  localparam int SB_MEM = 2;

  localparam int ST_INT = 0;
  localparam int ST_MEM = 1;
  localparam int ST_ERR = 2;

  typedef enum logic [1:0] {F_IDLE, F_FILL, F_FETCH, F_SEND} fl_st_e;
  typedef enum logic [1:0] {M_IDLE, M_FETCH, M_REQ} mem_st_e;
endpackage

// File: rtl/pgdma_pagebuf.sv
module pgdma_pagebuf #(
  parameter int WORDS = 128,
  parameter int DW    = 32,
  localparam int WAW  = $clog2(WORDS),
  localparam int NB   = DW / 8
) (
  input  logic           clk,
  input  logic [WAW-1:0] addr,
  input  logic [NB-1:0]  be,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    for (int b = 0; b < NB; b++) begin
      if (be[b]) store[addr][8*b +: 8] <= wdata[8*b +: 8];
    end
    rdata <= store[addr];
  end
endmodule

// File: rtl/pgdma_flash_side.sv
module pgdma_flash_side
  import pgdma_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  localparam int BW  = $clog2(PAGE_BYTES),
  localparam int WAW = BW - 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           dir_rd,
  input  logic           abort,
  input  logic           fl_in_valid,
  input  logic [7:0]     fl_in_data,
  output logic           fl_in_ready,
  output logic           fl_out_valid,
  output logic [7:0]     fl_out_data,
  input  logic           fl_out_ready,
  input  logic [31:0]    ram_rdata,
  output logic [WAW-1:0] ram_addr,
  output logic [3:0]     ram_be,
  output logic [31:0]    ram_wdata,
  output logic           busy,
  output logic           fin
);
  localparam logic [BW-1:0] LAST = BW'(PAGE_BYTES - 1);

  fl_st_e        st;
  logic [BW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= F_IDLE;
      cnt <= '0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (abort) begin
        st <= F_IDLE;
      end else begin
        case (st)
          F_IDLE: if (start) begin
            cnt <= '0;
            st  <= dir_rd ? F_FILL : F_FETCH;
          end
          F_FILL: if (fl_in_valid) begin
            if (cnt == LAST) begin
              st  <= F_IDLE;
              fin <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          F_FETCH: st <= F_SEND;
          F_SEND: if (fl_out_ready) begin
            if (cnt == LAST) begin
              st  <= F_IDLE;
              fin <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
              st  <= F_FETCH;
            end
          end
          default: st <= F_IDLE;
        endcase
      end
    end
  end

  assign fl_in_ready  = (st == F_FILL);
  assign fl_out_valid = (st == F_SEND);
  assign fl_out_data  = ram_rdata[{cnt[1:0], 3'b000} +: 8];
  assign ram_addr     = cnt[BW-1:2];
  assign ram_be       = (st == F_FILL && fl_in_valid) ? (4'b0001 << cnt[1:0]) : 4'b0000;
  assign ram_wdata    = {4{fl_in_data}};
  assign busy         = (st != F_IDLE);

  AST_FL_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    fl_out_valid && !fl_out_ready && !abort |=> fl_out_valid && $stable(fl_out_data)); // R12
  AST_FL_NO_MIX: assert property (@(posedge clk) disable iff (rst)
    !(fl_in_ready && fl_out_valid)); // R3
endmodule

// File: rtl/pgdma_mem_side.sv
module pgdma_mem_side
  import pgdma_pkg::*;
#(
  parameter int WORDS = 128,
  parameter int AW    = 32,
  localparam int WAW  = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           dir_rd,
  input  logic           abort,
  input  logic [AW-1:0]  base,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  input  logic [31:0]    mem_rdata,
  input  logic [31:0]    ram_rdata,
  output logic [WAW-1:0] ram_addr,
  output logic [3:0]     ram_be,
  output logic [31:0]    ram_wdata,
  output logic           busy,
  output logic           fin,
  output logic           err_evt
);
  localparam logic [WAW-1:0] LAST = WAW'(WORDS - 1);

  mem_st_e        st;
  logic [WAW-1:0] idx;
  logic [AW-1:0]  base_q;
  logic           we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= M_IDLE;
      idx     <= '0;
      base_q  <= '0;
      we_q    <= 1'b0;
      fin     <= 1'b0;
      err_evt <= 1'b0;
    end else begin
      fin     <= 1'b0;
      err_evt <= 1'b0;
      if (abort) begin
        st <= M_IDLE;
      end else begin
        case (st)
          M_IDLE: if (start) begin
            idx    <= '0;
            base_q <= base & ~AW'(3);
            we_q   <= dir_rd;
            st     <= M_FETCH;
          end
          M_FETCH: st <= M_REQ;
          M_REQ: begin
            if (mem_err) begin
              st      <= M_IDLE;
              err_evt <= 1'b1;
            end else if (mem_ack) begin
              if (idx == LAST) begin
                st  <= M_IDLE;
                fin <= 1'b1;
              end else begin
                idx <= idx + 1'b1;
                st  <= M_FETCH;
              end
            end
          end
          default: st <= M_IDLE;
        endcase
      end
    end
  end

  assign mem_req   = (st == M_REQ);
  assign mem_we    = we_q;
  assign mem_addr  = base_q + (AW'(idx) << 2);
  assign mem_wdata = ram_rdata;
  assign ram_addr  = idx;
  assign ram_be    = (st == M_REQ && mem_ack && !mem_err && !we_q) ? 4'hF : 4'h0;
  assign ram_wdata = mem_rdata;
  assign busy      = (st != M_IDLE);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !mem_err && !abort |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_ERR_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_err |=> !mem_req); // R10
endmodule

// File: rtl/pgdma_regs.sv
module pgdma_regs
  import pgdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          set_load,
  input  logic          clr_int,
  input  logic          clr_mem,
  input  logic [2:0]    st_set,
  output logic [2:0]    settings,
  output logic [DW-1:0] addr_q,
  output logic [2:0]    status,
  output logic          irq
);
  logic [2:0] ien;
  logic       wr_addr, wr_ien, wr_stat;

  assign wr_addr = reg_we && (reg_addr_e'(reg_addr) == RA_ADDR);
  assign wr_ien  = reg_we && (reg_addr_e'(reg_addr) == RA_IEN);
  assign wr_stat = reg_we && (reg_addr_e'(reg_addr) == RA_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      settings  <= '0;
      addr_q    <= '0;
      ien       <= '0;
      status    <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (set_load) settings <= reg_wdata[2:0];
      else settings <= settings & ~{clr_mem, clr_int, 1'b0};
      if (wr_addr) addr_q <= reg_wdata;
      if (wr_ien)  ien    <= reg_wdata[2:0];
      status <= (status & ~(wr_stat ? reg_wdata[2:0] : 3'b000)) | st_set;
      irq    <= |(status & ien);
      case (reg_addr_e'(reg_addr))
        RA_SET:  reg_rdata <= {{(DW-3){1'b0}}, settings};
        RA_ADDR: reg_rdata <= addr_q;
        RA_IEN:  reg_rdata <= {{(DW-3){1'b0}}, ien};
        default: reg_rdata <= {{(DW-3){1'b0}}, status};
      endcase
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == 3'b000) |=> !irq); // R8
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(settings[SB_INT] && settings[SB_MEM])); // R6
endmodule

// File: rtl/pgdma_engine.sv
module pgdma_engine
  import pgdma_pkg::*;
#(
  parameter int PAGE_BYTES = 512,
  parameter int AW         = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          done,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  input  logic          fl_in_valid,
  input  logic [7:0]    fl_in_data,
  output logic          fl_in_ready,
  output logic          fl_out_valid,
  output logic [7:0]    fl_out_data,
  input  logic          fl_out_ready
);
  localparam int DW    = 32;
  localparam int WORDS = PAGE_BYTES / (DW / 8);
  localparam int WAW   = $clog2(WORDS);

  logic [2:0]     settings, status;
  logic [DW-1:0]  addr_q;
  logic           stage;
  logic           fl_busy, fl_fin, mb_busy, mb_fin, mb_err;
  logic           wr_set, idle, exp_int, one_sel, no_sel;
  logic           good_start, bad_start, abort, fl_start, mb_start;
  logic [WAW-1:0] fl_ram_addr, mb_ram_addr, ram_addr;
  logic [3:0]     fl_ram_be, mb_ram_be, ram_be;
  logic [31:0]    fl_ram_wdata, mb_ram_wdata, ram_wdata, ram_rdata;

  assign wr_set     = reg_we && (reg_addr_e'(reg_addr) == RA_SET);
  assign idle       = !fl_busy && !mb_busy && !fl_fin && !mb_fin && !mb_err;
  assign exp_int    = (stage == 1'b0) == reg_wdata[SB_DIR];
  assign one_sel    = reg_wdata[SB_INT] ^ reg_wdata[SB_MEM];
  assign no_sel     = !reg_wdata[SB_INT] && !reg_wdata[SB_MEM];
  assign good_start = wr_set && idle && one_sel && (reg_wdata[SB_INT] == exp_int);
  assign bad_start  = wr_set && !no_sel && !good_start;
  assign abort      = wr_set && no_sel;
  assign fl_start   = good_start && reg_wdata[SB_INT];
  assign mb_start   = good_start && reg_wdata[SB_MEM];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= (fl_fin || mb_fin) && stage && !abort;
      if (abort || mb_err)       stage <= 1'b0;
      else if (fl_fin || mb_fin) stage <= ~stage;
    end
  end

  pgdma_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .set_load(good_start || abort), .clr_int(fl_fin), .clr_mem(mb_fin || mb_err),
    .st_set({bad_start || mb_err, mb_fin, fl_fin}),
    .settings(settings), .addr_q(addr_q), .status(status), .irq(irq)
  );

  pgdma_flash_side #(.PAGE_BYTES(PAGE_BYTES)) u_fl (
    .clk(clk), .rst(rst), .start(fl_start), .dir_rd(reg_wdata[SB_DIR]), .abort(abort),
    .fl_in_valid(fl_in_valid), .fl_in_data(fl_in_data), .fl_in_ready(fl_in_ready),
    .fl_out_valid(fl_out_valid), .fl_out_data(fl_out_data), .fl_out_ready(fl_out_ready),
    .ram_rdata(ram_rdata), .ram_addr(fl_ram_addr), .ram_be(fl_ram_be),
    .ram_wdata(fl_ram_wdata), .busy(fl_busy), .fin(fl_fin)
  );

  pgdma_mem_side #(.WORDS(WORDS), .AW(AW)) u_mb (
    .clk(clk), .rst(rst), .start(mb_start), .dir_rd(reg_wdata[SB_DIR]), .abort(abort),
    .base(addr_q[AW-1:0]), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .ram_rdata(ram_rdata), .ram_addr(mb_ram_addr), .ram_be(mb_ram_be),
    .ram_wdata(mb_ram_wdata), .busy(mb_busy), .fin(mb_fin), .err_evt(mb_err)
  );

  assign ram_addr  = fl_busy ? fl_ram_addr  : mb_ram_addr;
  assign ram_be    = fl_busy ? fl_ram_be    : mb_ram_be;
  assign ram_wdata = fl_busy ? fl_ram_wdata : mb_ram_wdata;

  pgdma_pagebuf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk(clk), .addr(ram_addr), .be(ram_be), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
    !(fl_busy && mb_busy)); // R5
  AST_FIN_CLEARS_SEL: assert property (@(posedge clk) disable iff (rst)
    fl_fin && !abort |=> !settings[SB_INT]); // R6
  AST_FILL_IS_READ: assert property (@(posedge clk) disable iff (rst)
    fl_in_ready |-> settings[SB_DIR]); // R3
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    mb_err |=> !done); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_ERR_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    mb_err |=> status[ST_ERR]); // R10
endmodule

// File: tb/sim_pgdma_engine.sv
module sim_pgdma_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        fl_in_valid = 1'b0;
  logic [7:0]  fl_in_data = '0;
  logic        fl_in_ready, fl_out_valid;
  logic [7:0]  fl_out_data;
  logic        fl_out_ready = 1'b0;

  always #10 clk = ~clk;

  pgdma_engine u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .fl_in_valid(fl_in_valid), .fl_in_data(fl_in_data),
    .fl_in_ready(fl_in_ready), .fl_out_valid(fl_out_valid), .fl_out_data(fl_out_data),
    .fl_out_ready(fl_out_ready)
  );

  int nvec = 0, nfail = 0, done_cnt = 0;
  bit finished = 0;
  logic [7:0]  fsrc [512];
  logic [31:0] msrc [128];
  logic [31:0] exp_a[$], exp_d[$];
  logic [7:0]  exp_b[$];
  int fk = 0, mbeat = 0, err_beat = 999, fcnt = 0;
  logic [31:0] rd_base = '0;
  bit pend = 0, gtog = 0, stall = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_status(input int bitpos, input string req);
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      reg_read(2'd3, v);
      if (v[bitpos]) return;
    end
    check(req, 32'd0, 32'd1 << bitpos);
  endtask

  // driver: push the expected memory writes of a page read
  task automatic push_page_writes(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      exp_a.push_back(base + 32'(4 * i));
      exp_d.push_back({fsrc[4*i+3], fsrc[4*i+2], fsrc[4*i+1], fsrc[4*i]});
    end
  endtask

  // memory responder and write monitor
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0; mem_err = 1'b0;
      if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          lat = mbeat % 3;
          if (mbeat == err_beat) mem_err = 1'b1;
          else begin
            mem_ack = 1'b1;
            if (mem_we) begin
              if (exp_a.size() == 0) check("R5 unexpected beat", mem_addr, 32'hFFFF_FFFF);
              else begin
                check("R2 write addr", mem_addr, exp_a.pop_front());
                check("R3 write data", mem_wdata, exp_d.pop_front());
              end
            end else begin
              check("R2 read addr", mem_addr, rd_base + 32'(4 * mbeat));
              mem_rdata = msrc[mbeat];
            end
            mbeat++;
          end
        end
      end
    end
  end

  // flash byte source
  initial begin
    forever begin
      @(negedge clk);
      if (pend) fk++;
      pend = 0; fl_in_valid = 1'b0;
      if (fl_in_ready && fk < 512) begin
        if (gtog) gtog = 0;
        else begin
          fl_in_valid = 1'b1; fl_in_data = fsrc[fk]; pend = 1;
          gtog = (fk % 9 == 4);
        end
      end
    end
  end

  // flash byte sink and monitor
  initial begin
    forever begin
      @(negedge clk);
      fl_out_ready = 1'b0;
      if (fl_out_valid) begin
        if (stall) stall = 0;
        else begin
          fl_out_ready = 1'b1;
          if (exp_b.size() == 0) check("R4 unexpected byte", {24'd0, fl_out_data}, 32'hFFFF_FFFF);
          else check("R4 flash byte", {24'd0, fl_out_data}, {24'd0, exp_b.pop_front()});
          stall = (fcnt % 5 == 0);
          fcnt++;
        end
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 512; k++) fsrc[k] = 8'((k * 7 + 3) & 255);
    for (int i = 0; i < 128; i++) msrc[i] = (32'(i) * 32'h0103_0507) ^ 32'hA5A5_0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    reg_read(2'd0, v); check("R1 settings", v, 0);
    reg_read(2'd1, v); check("R1 addr", v, 0);
    reg_read(2'd2, v); check("R1 ien", v, 0);
    reg_read(2'd3, v); check("R1 status", v, 0);
    check("R1 outputs", {27'd0, irq, done, mem_req, fl_in_ready, fl_out_valid}, 0);

    // page read: internal then memory
    reg_write(2'd2, 32'd7);
    reg_write(2'd1, 32'h1000_0003);
    reg_read(2'd1, v); check("R13 addr readback", v, 32'h1000_0003);
    fk = 0;
    reg_write(2'd0, 32'b011);
    wait_status(0, "R3 internal complete");
    reg_read(2'd0, v); check("R6 int select cleared", v, 32'b001);
    check("R9 no done after first", done_cnt, 0);
    check("R8 irq", {31'd0, irq}, 1);
    repeat (10) @(negedge clk);
    check("R6 no auto start", {31'd0, mem_req}, 0);
    reg_write(2'd3, 32'd1);
    reg_read(2'd3, v); check("R7 w1c", v, 0);
    push_page_writes(32'h1000_0000, 128);
    mbeat = 0;
    reg_write(2'd0, 32'b101);
    wait_status(1, "R3 memory complete");
    check("R2 all beats", exp_a.size(), 0);
    check("R9 done once", done_cnt, 1);

    // page write: ordering errors first
    reg_write(2'd3, 32'd7);
    reg_write(2'd0, 32'b010);
    reg_read(2'd3, v); check("R5 wrong order err", v, 32'b100);
    reg_read(2'd0, v); check("R5 settings unchanged", v, 32'b001);
    reg_write(2'd0, 32'b110);
    reg_read(2'd3, v); check("R5 both selects err", v, 32'b100);
    reg_write(2'd3, 32'd4);
    rd_base = 32'h2000_0000; mbeat = 0;
    reg_write(2'd1, 32'h2000_0000);
    reg_write(2'd0, 32'b100);
    reg_write(2'd0, 32'b100);
    wait_status(1, "R4 memory complete");
    reg_read(2'd3, v); check("R5 busy select err", v, 32'b110);
    reg_write(2'd3, 32'b010);
    reg_read(2'd3, v); check("R7 w1c partial", v, 32'b100);
    reg_write(2'd3, 32'b100);
    for (int i = 0; i < 128; i++)
      for (int b = 0; b < 4; b++) exp_b.push_back(msrc[i][8*b +: 8]);
    fcnt = 0;
    reg_write(2'd0, 32'b010);
    wait_status(0, "R4 internal complete");
    check("R4 all bytes", exp_b.size(), 0);
    check("R9 done twice", done_cnt, 2);

    // memory error mid-page
    reg_write(2'd3, 32'd7);
    for (int k = 0; k < 512; k++) fsrc[k] = 8'((k * 5 + 11) & 255);
    fk = 0;
    reg_write(2'd0, 32'b011);
    wait_status(0, "R10 fill");
    reg_write(2'd3, 32'd1);
    reg_write(2'd1, 32'h3000_0000);
    push_page_writes(32'h3000_0000, 5);
    mbeat = 0; err_beat = 5;
    reg_write(2'd0, 32'b101);
    wait_status(2, "R10 error flagged");
    repeat (3) @(negedge clk);
    reg_read(2'd3, v); check("R10 no mem complete", v, 32'b100);
    reg_read(2'd0, v); check("R10 select cleared", v, 32'b001);
    check("R10 req dropped", {31'd0, mem_req}, 0);
    check("R10 no done", done_cnt, 2);
    check("R10 beats before error", exp_a.size(), 0);
    err_beat = 999;
    reg_write(2'd3, 32'd4);
    reg_write(2'd0, 32'b101);
    repeat (4) @(negedge clk);
    reg_read(2'd3, v); check("R10 sequence rewound", v, 32'b100);
    check("R10 no restart", {31'd0, mem_req}, 0);
    reg_write(2'd3, 32'd4);

    // abort during fill, then full refill
    for (int k = 0; k < 512; k++) fsrc[k] = 8'((k * 13 + 1) & 255);
    fk = 0;
    reg_write(2'd0, 32'b011);
    repeat (60) @(negedge clk);
    reg_write(2'd0, 32'b001);
    repeat (2) @(negedge clk);
    check("R11 fill stopped", {31'd0, fl_in_ready}, 0);
    repeat (5) @(negedge clk);
    reg_read(2'd3, v); check("R11 no status", v, 0);
    reg_read(2'd0, v); check("R11 settings", v, 32'b001);
    fk = 0;
    reg_write(2'd0, 32'b011);
    wait_status(0, "R11 refill");
    reg_write(2'd3, 32'd1);
    push_page_writes(32'h3000_0000, 128);
    mbeat = 0;
    reg_write(2'd0, 32'b101);
    wait_status(1, "R11 memory after refill");
    check("R11 all beats", exp_a.size(), 0);
    check("R9 done third", done_cnt, 3);
    reg_write(2'd2, 32'd0);
    repeat (2) @(negedge clk);
    check("R8 irq masked", {31'd0, irq}, 0);
    reg_write(2'd0, 32'd0);
    repeat (3) @(negedge clk);
    check("R11 idle", {29'd0, mem_req, fl_in_ready, fl_out_valid}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule